// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block turns a physical address into a choice among eight chip-select regions. Each region has a 12-bit configuration word made up of a 6-bit base, a valid flag and a 4-bit mask. The mask controls how many of address bits [27:24] take part in the compare, and so it sets the region size: 16, 32, 64 or 128 MB, or 256 MB when a build parameter allows it. The block drives a one-hot select, a hit flag, a flag for addresses that land in more than one region, and the offset inside the chosen region.

Software programs the regions through a simple write port, one region per write. A read port is selected by index and returns a region's word in the same cycle. A separate per-region flag marks any region whose mask holds a value that the region-size scheme does not support. Address decode is combinational, so the outputs follow the address in the same cycle. Configuration writes are registered.

Top module: `cs_decoder`

## Requirements
- R1: After reset every region's word reads 0xF00 (mask 0xF, base 0, not valid), except region 0, which reads 0xF40 (valid set). Region 0 therefore selects any address whose bits [29:24] are all zero.
- R2: A write stores `wr_data & 0xF7F` into region `wr_idx`: mask in bits [11:8], valid in bit 6, base in bits [5:0]. Bits 7 and [31:12] always read as zero. The new word shows on `rd_data` and takes effect in the decode from the cycle after the write edge. Other regions keep their words.
- R3: Region i matches when its valid bit is set and `addr[29:24] & {2'b11,mask}` equals `base & {2'b11,mask}`. A region with valid clear never matches. `hit` is high when any region matches.
- R4: Address bits that the mask clears, and address bits [31:30], do not affect matching. The same region therefore repeats across every mask-aligned window.
- R5: When several regions match, `cs_sel` is one-hot on the lowest matching index and `multi_hit` is high. `cs_sel` never has more than one bit set.
- R6: On a hit, `offset` equals `{addr[27:24] & ~mask, addr[23:0]}` using the winning region's mask. With no hit, `offset` is zero.
- R7: `cfg_err[i]` is high when region i's mask is not 0x8, 0xC, 0xE or 0xF. It is also high for a mask of 0x0, unless the parameter ALLOW_256 is 1. The valid bit does not affect this flag.
- R8: A write whose writable bits equal the stored word leaves the word and the decode unchanged. Without a write, no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IW | Region written |
| wr_data | input | 32 | Write data |
| rd_idx | input | IW | Region read back |
| rd_data | output | 32 | Region word, combinational |
| addr | input | AW | Physical address to decode |
| cs_sel | output | NCS | One-hot region select |
| hit | output | 1 | Some region matches |
| multi_hit | output | 1 | More than one region matches |
| offset | output | 28 | Offset within the selected region |
| cfg_err | output | NCS | Per-region unsupported-mask flag |

## Verification
The decode outputs (`cs_sel`, `hit`, `multi_hit`, `offset`) and `rd_data` depend on their inputs with no register in between. The bench therefore sets `addr` or `rd_idx` and samples one time step later, well away from any clock edge. A write is driven on a falling edge and lands on the next rising edge. Its effect on `rd_data`, the decode and `cfg_err` is checked only after the following falling edge, which is the first point where R2 says it is visible. The unchanged-write case is checked at the ports: the same address is decoded and the same word read back before and after that write.

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int NCS = 8,
  parameter int AW = 32,
  parameter bit ALLOW_256 = 1'b0,
  parameter int IW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [31:0]    wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic [31:0]    rd_data,
  input  logic [AW-1:0]  addr,
  output logic [NCS-1:0] cs_sel,
  output logic           hit,
  output logic           multi_hit,
  output logic [27:0]    offset,
  output logic [NCS-1:0] cfg_err
);
  localparam logic [11:0] WMASK = 12'hF7F;
  localparam logic [11:0] RST_WORD = 12'hF00;
  localparam int VBIT = 6;

  logic [NCS-1:0][11:0] cfg_q;
  logic [NCS-1:0] match;
  logic [IW-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++)
        cfg_q[i] <= (i == 0) ? (RST_WORD | 12'(1 << VBIT)) : RST_WORD;
    end else if (wr_en) begin
      cfg_q[wr_idx] <= wr_data[11:0] & WMASK;
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    wire [3:0] m = cfg_q[g][11:8];
    wire [5:0] cmp = {2'b11, m};
    assign match[g] = cfg_q[g][VBIT] && ((addr[29:24] & cmp) == (cfg_q[g][5:0] & cmp));
    assign cfg_err[g] = !(m == 4'h8 || m == 4'hC || m == 4'hE || m == 4'hF)
                        && !(ALLOW_256 && m == 4'h0);
  end

  always_comb begin
    cs_sel = '0;
    win = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (match[i]) begin
        cs_sel = '0;
        cs_sel[i] = 1'b1;
        win = IW'(i);
      end
    end
  end

  assign hit = |match;
  assign multi_hit = (match & (match - 1'b1)) != '0;
  assign offset = hit ? {addr[27:24] & ~cfg_q[win][11:8], addr[23:0]} : 28'h0;
  assign rd_data = {20'h0, cfg_q[rd_idx]};
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
  parameter int NCS = 8,
  parameter int IW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [IW-1:0]        wr_idx,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_data,
  input logic [NCS-1:0]       cs_sel,
  input logic                 hit,
  input logic                 multi_hit,
  input logic [NCS-1:0][11:0] cfg_q
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_sel)); // R5
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) multi_hit |-> hit); // R5
  AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n) hit == (cs_sel != '0)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q[$past(wr_idx)] == ($past(wr_data[11:0]) & 12'hF7F)); // R2
  AST_RDATA_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:12] == '0 && !rd_data[7]); // R2
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(cfg_q)); // R8
  for (genvar g = 0; g < NCS; g++) begin : g_v
    AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !cfg_q[g][6] |-> !cs_sel[g]); // R3
  end
endmodule

bind cs_decoder cs_decoder_chk #(.NCS(NCS), .IW(IW)) chk (.*);

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0, addr = 0, rd_data, rd_data_w;
  logic [7:0] cs_sel, cfg_err, cs_sel_w, cfg_err_w;
  logic hit, multi_hit, hit_w, multi_hit_w;
  logic [27:0] offset, offset_w;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_decoder uut (.clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_idx, .rd_data, .addr,
    .cs_sel, .hit, .multi_hit, .offset, .cfg_err);
  cs_decoder #(.ALLOW_256(1'b1)) uut_w (.clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_idx,
    .rd_data(rd_data_w), .addr, .cs_sel(cs_sel_w), .hit(hit_w), .multi_hit(multi_hit_w),
    .offset(offset_w), .cfg_err(cfg_err_w));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic probe(logic [31:0] a, logic [7:0] sel, logic h, logic mh, logic [27:0] off, string req);
    addr = a; #1;
    check({req, " sel"}, 32'(cs_sel), 32'(sel));
    check({req, " hit"}, 32'(hit), 32'(h));
    check({req, " multi"}, 32'(multi_hit), 32'(mh));
    check({req, " offset"}, 32'(offset), 32'(off));
  endtask

  task automatic rd(int idx, logic [31:0] exp, string req);
    rd_idx = 3'(idx); #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rd(0, 32'hF40, "R1 cs0 word");
    rd(3, 32'hF00, "R1 cs3 word");
    rd(7, 32'hF00, "R1 cs7 word");
    check("R1 cfg_err", 32'(cfg_err), 0);
    probe(32'h00ABCDEF, 8'h01, 1, 0, 28'h0ABCDEF, "R1 cs0 hit");
    probe(32'h01000000, 8'h00, 0, 0, 28'h0, "R1 miss");
  endtask

  task automatic t_write;
    wr(2, 32'hFFFFFFFF);
    rd(2, 32'hF7F, "R2 writable bits");
    rd(3, 32'hF00, "R2 neighbour kept");
    probe(32'h3F000010, 8'h04, 1, 0, 28'h10, "R3 base 3F");
    wr(2, 32'h00000C45);
    rd(2, 32'hC45, "R2 readback");
  endtask

  task automatic t_alias;
    probe(32'h04000000, 8'h04, 1, 0, 28'h0, "R4 window low");
    probe(32'h07123456, 8'h04, 1, 0, 28'h3123456, "R6 window high");
    probe(32'h08000000, 8'h00, 0, 0, 28'h0, "R4 outside");
    probe(32'hC5000000, 8'h04, 1, 0, 28'h1000000, "R4 top bits ignored");
  endtask

  task automatic t_valid;
    wr(2, 32'h00000C05);
    probe(32'h05000000, 8'h00, 0, 0, 28'h0, "R3 invalid no match");
  endtask

  task automatic t_prio;
    wr(5, 32'h00000840);
    probe(32'h00000100, 8'h01, 1, 1, 28'h100, "R5 lowest wins");
    probe(32'h07000000, 8'h20, 1, 0, 28'h7000000, "R6 mask 8 offset");
  endtask

  task automatic t_same;
    wr(5, 32'hABCD08C0);
    rd(5, 32'h840, "R8 word unchanged");
    probe(32'h07000000, 8'h20, 1, 0, 28'h7000000, "R8 decode unchanged");
    probe(32'h00000100, 8'h01, 1, 1, 28'h100, "R8 priority unchanged");
  endtask

  task automatic t_err;
    wr(6, 32'h00000300);
    check("R7 mask 3", 32'(cfg_err), 32'h40);
    check("R7 mask 3 wide", 32'(cfg_err_w), 32'h40);
    wr(6, 32'h00000000);
    check("R7 mask 0", 32'(cfg_err), 32'h40);
    check("R7 mask 0 allowed", 32'(cfg_err_w), 32'h00);
    wr(6, 32'h00000E00);
    check("R7 mask E", 32'(cfg_err), 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_write; t_alias; t_valid; t_prio; t_same; t_err;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule